// File: doc/BRIEF.md
# DDR SDRAM Initialization Command Issuer

This block lets software walk a DDR SDRAM through its power-up sequence one command at a time. Software first writes a command code into a small mode register. It then makes a dummy write anywhere in the memory window. That write makes the block place exactly one command on the DDR command pins for one memory clock cycle, and then answer the write with a one-cycle ready pulse. The memory clock is taken to be the block clock.

Some commands have side effects. The first plain NOP that is acknowledged after reset turns on the clock drivers toward the device. The second one raises CKE. Both stay on until reset. Bank select and row bits come from the address of the dummy write. For load-mode cycles, the DLL-reset bit comes from a configuration register. In normal mode (code 0), window writes issue nothing and are flagged for pass-through to the data path.

The block waits for no delay of its own. Pauses, DLL lock cycles and the spacing of refreshes are left to software. The address input carries byte-address bits 23:10 of the window offset, for a 16-bit device with 9 column bits, 12 row bits and 4 banks. Bits 21:10 are the row and bits 23:22 are the bank.

Top module: `ddr_init_cmd_issuer`

## Requirements
- R1: After reset the block is in the following state:
  - the command pins {cs_n, ras_n, cas_n, we_n} show NOP (0111);
  - ck_en, cke, mem_ready and mem_passthru are low;
  - the mode register holds 0.
- R2: A window write accepted in a nonzero mode drives the command pins for exactly one cycle, in the cycle after the accepting edge. The command depends on the mode code:
  - codes 1, 6 and 7 drive NOP (0111);
  - code 2 drives precharge-all (0010);
  - codes 3 and 5 drive load-mode (0000);
  - code 4 drives auto-refresh (0001).
  
  The pins return to NOP afterwards.
- R3: mem_ready is high for exactly one cycle, in the cycle right after the command cycle. It is low at all other times.
- R4: The first acknowledged write in mode 1 after reset sets ck_en high in the command cycle. ck_en stays high until reset.
- R5: The second acknowledged write in mode 1 sets cke high. cke is never high while ck_en is low, and it stays high until reset. Later mode-1 writes change neither output.
- R6: Writes in modes 6 and 7 change neither ck_en nor cke.
- R7: For precharge and load-mode commands, ba equals address bits 23:22 of the write. For auto-refresh, ba and a are both zero.
- R8: For load-mode commands, a[11:0] equals address bits 21:10 of the write, with one exception: in mode 3, a[8] is replaced by the DLL-reset configuration bit.
- R9: For precharge-all, a[10] is 1 and every other address pin is 0.
- R10: In mode 0, mem_passthru is high while mem_wr is high and the block is idle. No command is driven and no ready pulse is given.
- R11: Each accepted write issues exactly one command. Two writes in mode 4 give two separate refresh cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 3 | Mode code to store |
| cfg_wr | input | 1 | Write strobe for the DLL-reset configuration bit |
| cfg_dll_rst | input | 1 | DLL-reset bit value to store |
| mem_wr | input | 1 | Window write request, held until mem_ready |
| mem_addr_hi | input | 14 | Byte-address bits 23:10 of the write (bank, row) |
| mem_ready | output | 1 | One-cycle acknowledge of an issued command |
| mem_passthru | output | 1 | Write belongs to the normal data path (mode 0) |
| ck_en | output | 1 | Enable for the memory clock drivers |
| cke | output | 1 | Memory clock enable pin |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address pins |
| a | output | 12 | Address pins |

## Verification
The checker watches every cycle for several properties:
- a command lasts one cycle and is followed by exactly one ready pulse;
- ck_en and cke only turn on and never turn off, and cke only ever comes after ck_en;
- precharge, refresh and load-mode cycles carry the right bank and address patterns relative to the write address;
- a pass-through write produces no bus activity.

Only the bench scenarios can show the effects that depend on history. These are: the NOP count that decides the clock and CKE side effects, the absence of side effects in the reserved codes, the DLL bit following later configuration writes, and two refresh writes giving two distinct cycles.

// File: rtl/ddr_init_pkg.sv
// Package: shared encodings for the DDR initialization command issuer.
// Assumes command pins ordered {cs_n, ras_n, cas_n, we_n}.
package ddr_init_pkg;

    // Software-visible mode codes
    typedef enum logic [2:0] {
        MODE_RUN  = 3'd0,
        MODE_NOP  = 3'd1,
        MODE_PALL = 3'd2,
        MODE_MRS  = 3'd3,
        MODE_REF  = 3'd4,
        MODE_EMRS = 3'd5,
        MODE_RSV6 = 3'd6,
        MODE_RSV7 = 3'd7
    } mode_e;

    // DDR command pin patterns
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } cmd_e;

    // Sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_DRIVE = 2'd1,
        SEQ_ACK   = 2'd2
    } seq_e;

endpackage

// File: rtl/ddr_init_regs.sv
// Module: software-written mode register and DLL-reset configuration bit.
// Assumes single-cycle write strobes; values hold until rewritten or reset.
module ddr_init_regs
    import ddr_init_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [2:0] mode_wdata,
    input  logic       cfg_wr,
    input  logic       cfg_dll_rst,
    output mode_e      mode_q,
    output logic       dll_q
);

    // Mode register: selects which command the next window write issues
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_RUN;
        else if (mode_wr)
            mode_q <= mode_e'(mode_wdata);
    end

    // DLL-reset field of the configuration register
    always_ff @(posedge clk) begin
        if (!rst_n)
            dll_q <= 1'b0;
        else if (cfg_wr)
            dll_q <= cfg_dll_rst;
    end

endmodule

// File: rtl/ddr_init_cmd_map.sv
// Module: combinational decode of mode code and write address into the
// command pattern, bank and address pins that the next command carries.
// Assumes addr_hi = {bank bits, row bits} of the byte address.
module ddr_init_cmd_map
    import ddr_init_pkg::*;
#(
    parameter int ROW_W   = 12,
    parameter int BANK_W  = 2,
    parameter int AP_BIT  = 10,
    parameter int DLL_BIT = 8
) (
    input  mode_e                    mode,
    input  logic                     dll,
    input  logic [BANK_W+ROW_W-1:0]  addr_hi,
    output cmd_e                     cmd,
    output logic [BANK_W-1:0]        ba,
    output logic [ROW_W-1:0]         a,
    output logic                     is_plain_nop
);

    localparam int BANK_LSB = ROW_W;

    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;

    // Split the address into row and bank fields
    always_comb begin
        row  = addr_hi[ROW_W-1:0];
        bank = addr_hi[BANK_LSB +: BANK_W];
    end

    // Translate the mode code into the pin pattern of one command
    always_comb begin
        cmd          = CMD_NOP;
        ba           = '0;
        a            = '0;
        is_plain_nop = 1'b0;
        case (mode)
            MODE_NOP: begin
                is_plain_nop = 1'b1;
            end
            MODE_PALL: begin
                cmd       = CMD_PRE;
                ba        = bank;
                a[AP_BIT] = 1'b1;
            end
            MODE_MRS: begin
                cmd        = CMD_LMR;
                ba         = bank;
                a          = row;
                a[DLL_BIT] = dll;
            end
            MODE_EMRS: begin
                cmd = CMD_LMR;
                ba  = bank;
                a   = row;
            end
            MODE_REF: begin
                cmd = CMD_REF;
            end
            default: begin
                cmd = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/ddr_init_seq.sv
// Module: accepts one window write at a time, drives the decoded command
// for one cycle, then pulses ready; tracks the clock/CKE power-up effects.
// Assumes the requester holds mem_wr until it sees the ready pulse.
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_wr,
    input  mode_e             mode,
    input  cmd_e              nxt_cmd,
    input  logic [BANK_W-1:0] nxt_ba,
    input  logic [ROW_W-1:0]  nxt_a,
    input  logic              nxt_plain_nop,
    output cmd_e              cmd_q,
    output logic [BANK_W-1:0] ba_q,
    output logic [ROW_W-1:0]  a_q,
    output logic              ready_q,
    output logic              ck_en_q,
    output logic              cke_q,
    output logic              idle
);

    seq_e state;
    logic accept;

    // A write is taken only when idle and an init mode is programmed
    always_comb begin
        idle   = (state == SEQ_IDLE);
        accept = idle && mem_wr && (mode != MODE_RUN);
    end

    // Handshake state: idle -> command cycle -> ready cycle -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            ready_q <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    ready_q <= 1'b0;
                    if (accept)
                        state <= SEQ_DRIVE;
                end
                SEQ_DRIVE: begin
                    ready_q <= 1'b1;
                    state   <= SEQ_ACK;
                end
                default: begin
                    ready_q <= 1'b0;
                    state   <= SEQ_IDLE;
                end
            endcase
        end
    end

    // Command bus register: decoded command for one cycle, NOP otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_NOP;
            ba_q  <= '0;
            a_q   <= '0;
        end else if (accept) begin
            cmd_q <= nxt_cmd;
            ba_q  <= nxt_ba;
            a_q   <= nxt_a;
        end else begin
            cmd_q <= CMD_NOP;
            ba_q  <= '0;
            a_q   <= '0;
        end
    end

    // Power-up side effects: first NOP enables clocks, second raises CKE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_en_q <= 1'b0;
            cke_q   <= 1'b0;
        end else if (accept && nxt_plain_nop) begin
            ck_en_q <= 1'b1;
            if (ck_en_q)
                cke_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ddr_init_cmd_issuer.sv
// Module: top of the DDR initialization command issuer. Software programs
// a mode code, then each window write issues one command on the DDR pins.
// Assumes memory clock equals clk and mem_addr_hi holds byte-address
// bits above the column and byte-select fields.
module ddr_init_cmd_issuer
    import ddr_init_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int BANK_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_wr,
    input  logic [2:0]              mode_wdata,
    input  logic                    cfg_wr,
    input  logic                    cfg_dll_rst,
    input  logic                    mem_wr,
    input  logic [BANK_W+ROW_W-1:0] mem_addr_hi,
    output logic                    mem_ready,
    output logic                    mem_passthru,
    output logic                    ck_en,
    output logic                    cke,
    output logic                    cs_n,
    output logic                    ras_n,
    output logic                    cas_n,
    output logic                    we_n,
    output logic [BANK_W-1:0]       ba,
    output logic [ROW_W-1:0]        a
);

    localparam int AP_BIT  = 10;
    localparam int DLL_BIT = 8;

    mode_e             mode_q;
    logic              dll_q;
    cmd_e              map_cmd;
    logic [BANK_W-1:0] map_ba;
    logic [ROW_W-1:0]  map_a;
    logic              map_plain_nop;
    cmd_e              bus_cmd;
    logic              seq_idle;

    ddr_init_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr     (mode_wr),
        .mode_wdata  (mode_wdata),
        .cfg_wr      (cfg_wr),
        .cfg_dll_rst (cfg_dll_rst),
        .mode_q      (mode_q),
        .dll_q       (dll_q)
    );

    ddr_init_cmd_map #(
        .ROW_W   (ROW_W),
        .BANK_W  (BANK_W),
        .AP_BIT  (AP_BIT),
        .DLL_BIT (DLL_BIT)
    ) u_map (
        .mode         (mode_q),
        .dll          (dll_q),
        .addr_hi      (mem_addr_hi),
        .cmd          (map_cmd),
        .ba           (map_ba),
        .a            (map_a),
        .is_plain_nop (map_plain_nop)
    );

    ddr_init_seq #(
        .ROW_W  (ROW_W),
        .BANK_W (BANK_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .mem_wr        (mem_wr),
        .mode          (mode_q),
        .nxt_cmd       (map_cmd),
        .nxt_ba        (map_ba),
        .nxt_a         (map_a),
        .nxt_plain_nop (map_plain_nop),
        .cmd_q         (bus_cmd),
        .ba_q          (ba),
        .a_q           (a),
        .ready_q       (mem_ready),
        .ck_en_q       (ck_en),
        .cke_q         (cke),
        .idle          (seq_idle)
    );

    // Drive the command pins from the registered command
    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = bus_cmd;
    end

    // Normal-mode writes are flagged for the data path
    always_comb begin
        mem_passthru = mem_wr && seq_idle && (mode_q == MODE_RUN);
    end

endmodule

// File: rtl/ddr_init_cmd_issuer_chk.sv
// Checker: cycle-by-cycle properties of the command issuer's ports.
// Assumes command pins ordered {cs_n, ras_n, cas_n, we_n}.
module ddr_init_cmd_issuer_chk #(
    parameter int ROW_W  = 12,
    parameter int BANK_W = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [3:0]              cmd_pins,
    input logic [BANK_W-1:0]       ba,
    input logic [ROW_W-1:0]        a,
    input logic                    mem_ready,
    input logic                    mem_passthru,
    input logic                    ck_en,
    input logic                    cke,
    input logic [BANK_W+ROW_W-1:0] mem_addr_hi
);

    localparam logic [3:0]       P_NOP    = 4'b0111;
    localparam logic [3:0]       P_PRE    = 4'b0010;
    localparam logic [3:0]       P_REF    = 4'b0001;
    localparam logic [3:0]       P_LMR    = 4'b0000;
    localparam logic [ROW_W-1:0] AP_MASK  = ROW_W'(1) << 10;
    localparam logic [ROW_W-1:0] DLL_MASK = ROW_W'(1) << 8;

    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pins != P_NOP) |=> (cmd_pins == P_NOP));                          // R2
    AST_READY_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pins != P_NOP) |=> mem_ready);                                    // R3
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |=> !mem_ready);                                             // R3
    AST_CLK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ck_en |=> ck_en);                                                      // R4
    AST_CKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);                                                          // R5
    AST_CKE_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        cke |-> ck_en);                                                        // R5
    AST_BANK_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_pins == P_PRE) || (cmd_pins == P_LMR))
            |-> (ba == $past(mem_addr_hi[ROW_W +: BANK_W])));                  // R7
    AST_REF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pins == P_REF) |-> ((ba == '0) && (a == '0)));                    // R7
    AST_LMR_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pins == P_LMR)
            |-> ((a & ~DLL_MASK) == ($past(mem_addr_hi[ROW_W-1:0]) & ~DLL_MASK))); // R8
    AST_PRE_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pins == P_PRE) |-> (a == AP_MASK));                               // R9
    AST_PASSTHRU_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_passthru |=> ((cmd_pins == P_NOP) && !mem_ready));                 // R10

endmodule

bind ddr_init_cmd_issuer ddr_init_cmd_issuer_chk #(
    .ROW_W  (ROW_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_pins     ({cs_n, ras_n, cas_n, we_n}),
    .ba           (ba),
    .a            (a),
    .mem_ready    (mem_ready),
    .mem_passthru (mem_passthru),
    .ck_en        (ck_en),
    .cke          (cke),
    .mem_addr_hi  (mem_addr_hi)
);

// File: tb/ddr_init_cmd_issuer_test.sv
`timescale 1ns/1ps
module ddr_init_cmd_issuer_test;

    localparam time        CLK_HALF = 10ns;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_LMR = 4'b0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [2:0]  mode_wdata = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_dll_rst = 1'b0;
    logic        mem_wr = 1'b0;
    logic [13:0] mem_addr_hi = '0;
    logic        mem_ready, mem_passthru, ck_en, cke;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] a;

    int n_cmp = 0;
    int n_bad = 0;
    logic [17:0] exp_q[$];   // {cmd[3:0], ba[1:0], a[11:0]}

    ddr_init_cmd_issuer uut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .cfg_wr(cfg_wr), .cfg_dll_rst(cfg_dll_rst), .mem_wr(mem_wr),
        .mem_addr_hi(mem_addr_hi), .mem_ready(mem_ready),
        .mem_passthru(mem_passthru), .ck_en(ck_en), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .a(a)
    );

    always #CLK_HALF clk = ~clk;

    // Compare one value and record the outcome
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: every non-NOP command on the pins must match the queue head
    always @(negedge clk) begin
        if (rst_n && ({cs_n, ras_n, cas_n, we_n} != C_NOP)) begin
            if (exp_q.size() == 0)
                chk("R11 unexpected command", {14'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, C_NOP});
            else
                chk("R2 R7 R8 R9 command fields", {14'd0, cs_n, ras_n, cas_n, we_n, ba, a},
                    {14'd0, exp_q.pop_front()});
        end
    end

    task automatic set_mode(input logic [2:0] m);
        mode_wdata = m;
        mode_wr    = 1'b1;
        @(negedge clk);
        mode_wr    = 1'b0;
    endtask

    task automatic set_dll(input logic b);
        cfg_dll_rst = b;
        cfg_wr      = 1'b1;
        @(negedge clk);
        cfg_wr      = 1'b0;
    endtask

    // Driver: push the expected command, make one window write, check handshake
    task automatic fire(input logic [23:0] addr, input logic vld,
                        input logic [3:0] ec, input logic [1:0] eba, input logic [11:0] ea);
        if (vld) exp_q.push_back({ec, eba, ea});
        mem_addr_hi = addr[23:10];
        mem_wr      = 1'b1;
        @(negedge clk);   // command cycle
        chk("R3 ready low in command cycle", {31'd0, mem_ready}, 32'd0);
        if (!vld) chk("R2 NOP-type mode keeps bus at NOP", {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, C_NOP});
        @(negedge clk);   // ready cycle
        chk("R3 ready pulse", {31'd0, mem_ready}, 32'd1);
        chk("R2 bus back to NOP", {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, C_NOP});
        mem_wr = 1'b0;
        @(negedge clk);
        chk("R3 ready single cycle", {31'd0, mem_ready}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(2ms);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cmd NOP", {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, C_NOP});
        chk("R1 ck_en", {31'd0, ck_en}, 32'd0);
        chk("R1 cke", {31'd0, cke}, 32'd0);
        chk("R1 ready", {31'd0, mem_ready}, 32'd0);
        chk("R1 passthru", {31'd0, mem_passthru}, 32'd0);

        // R6 reserved codes have no side effects
        set_mode(3'd7);
        fire(24'h000000, 1'b0, C_NOP, 2'd0, 12'd0);
        set_mode(3'd6);
        fire(24'h000000, 1'b0, C_NOP, 2'd0, 12'd0);
        chk("R6 ck_en unchanged", {31'd0, ck_en}, 32'd0);
        chk("R6 cke unchanged", {31'd0, cke}, 32'd0);

        // R4 first NOP enables clocks; R5 second raises CKE
        set_mode(3'd1);
        fire(24'h123400, 1'b0, C_NOP, 2'd0, 12'd0);
        chk("R4 ck_en after first NOP", {31'd0, ck_en}, 32'd1);
        chk("R5 cke still low after first NOP", {31'd0, cke}, 32'd0);
        fire(24'h000000, 1'b0, C_NOP, 2'd0, 12'd0);
        chk("R5 cke after second NOP", {31'd0, cke}, 32'd1);
        fire(24'h000000, 1'b0, C_NOP, 2'd0, 12'd0);
        chk("R4 ck_en held", {31'd0, ck_en}, 32'd1);
        chk("R5 cke held", {31'd0, cke}, 32'd1);

        // R9 R7 precharge all: bank from address, only A10 set
        set_mode(3'd2);
        fire(24'hBFFC00, 1'b1, C_PRE, 2'd2, 12'h400);

        // R8 extended mode set: nonzero bank, row onto A
        set_mode(3'd5);
        fire({2'b01, 12'h002, 10'd0}, 1'b1, C_LMR, 2'd1, 12'h002);

        // R8 mode set with DLL reset high: A8 forced to 1
        set_dll(1'b1);
        set_mode(3'd3);
        fire({2'b00, 12'h032, 10'd0}, 1'b1, C_LMR, 2'd0, 12'h132);

        // R11 R7 two refresh writes give two refresh cycles
        set_mode(3'd4);
        fire(24'hC0FC00, 1'b1, C_REF, 2'd0, 12'd0);
        fire(24'hC0FC00, 1'b1, C_REF, 2'd0, 12'd0);

        // R8 mode set with DLL reset cleared: A8 forced to 0
        set_dll(1'b0);
        set_mode(3'd3);
        fire({2'b00, 12'h1FF, 10'd0}, 1'b1, C_LMR, 2'd0, 12'h0FF);

        // R10 normal mode: pass-through, no command, no ready
        set_mode(3'd0);
        mem_addr_hi = 14'h1ABC;
        mem_wr = 1'b1;
        #1;
        chk("R10 passthru while writing", {31'd0, mem_passthru}, 32'd1);
        @(negedge clk);
        mem_wr = 1'b0;
        #1;
        chk("R10 passthru drops", {31'd0, mem_passthru}, 32'd0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 no ready in normal mode", {31'd0, mem_ready}, 32'd0);
        end

        chk("R11 all expected commands seen", exp_q.size(), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule